// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block turns a 32-bit fixed-length instruction word from a small load/store RISC subset into the control bundle for one execute step. One primary opcode field selects one of three field layouts: a register form (two sources, a destination, a shift amount and a function code), an immediate form (two registers and a 16-bit constant) and a jump form (a 26-bit target). The secondary function code is read only when the opcode selects the register form. Jump-through-register is one of the register-form operations.

The decoded fields and control signals are captured in one output register stage. The register has a synchronous active-high reset, so a pipeline can hand it a new word on every cycle and read the decoded controls one clock later. The supported operations are add, sub, set-less-than, jump-register, add-immediate, or-immediate, load-upper, load word, store word, branch-if-equal, branch-if-not-equal, jump and jump-and-link. Every other encoding raises the illegal output and turns off every write, memory and control-flow enable.

Top module: `tfd_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every output becomes zero on that edge. Otherwise every output reflects the `i_instr` sampled at the previous rising edge, so the latency is one cycle.
- R2: The field outputs are taken from fixed bit positions: rs = [25:21], rt = [20:16], rd = [15:11], shamt = [10:6], immediate = [15:0] and target = [25:0]. They follow the word whatever it encodes, legal or not.
- R3: With opcode 000000, funct 100000 (add), 100010 (sub) and 101010 (slt) write the rd field. For these, dst_sel = 0 and alu_op is 0 (add), 1 (sub) or 2 (slt). ext_mode is 0.
- R4: Opcode 000000 with funct 001000 (jump-register) sets jreg, with no register write and no memory access. dst_sel, dst_idx and alu_op are all 0.
- R5: Immediate handling is carried in ext_mode: 0 = sign-extend, 1 = zero-extend, 2 = place in upper half with the low half zero. addi (001000), lw (100011), sw (101011), beq (000100) and bne (000101) give 0. ori (001101) gives 1, with alu_op 3 (or). lui (001111) gives 2, with alu_op 4 (pass upper). addi, ori and lui write the rt field (dst_sel = 1). addi uses alu_op 0.
- R6: lw (100011) sets mem_rd and writes rt (dst_sel = 1, alu_op 0). sw (101011) sets mem_wr with no register write, dst_sel = 0 and dst_idx = 0. mem_rd and mem_wr are never high together.
- R7: beq (000100) sets br_eq and bne (000101) sets br_ne, each with alu_op 1 (sub) and no register write.
- R8: j (000010) sets jump alone. jal (000011) sets jump and link, writes register 31 with dst_sel = 2 and dst_idx = 31, and keeps alu_op 0.
- R9: Whenever the selected destination register index is 0, reg_we stays low, while dst_sel and dst_idx still show the selection.
- R10: Any opcode not listed above, or opcode 000000 with an unlisted funct, sets illegal and drives every control output other than illegal to zero (the field outputs still follow R2).
- R11: At most one of br_eq, br_ne, jump and jreg is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| i_instr | input | 32 | Instruction word to decode |
| o_rs | output | 5 | First source register field |
| o_rt | output | 5 | Second source / immediate-form destination field |
| o_rd | output | 5 | Register-form destination field |
| o_shamt | output | 5 | Shift amount field |
| o_imm | output | 16 | Immediate field, unextended |
| o_target | output | 26 | Jump target field |
| o_reg_we | output | 1 | Register write enable |
| o_dst_sel | output | 2 | Destination source: 0 rd, 1 rt, 2 link |
| o_dst_idx | output | 5 | Selected destination register index |
| o_alu_op | output | 3 | 0 add, 1 sub, 2 slt, 3 or, 4 pass upper |
| o_ext_mode | output | 2 | 0 sign, 1 zero, 2 upper-half |
| o_mem_rd | output | 1 | Memory read (load) |
| o_mem_wr | output | 1 | Memory write (store) |
| o_br_eq | output | 1 | Branch if equal |
| o_br_ne | output | 1 | Branch if not equal |
| o_jump | output | 1 | Absolute jump |
| o_link | output | 1 | Save return address |
| o_jreg | output | 1 | Jump through register |
| o_illegal | output | 1 | Unrecognised encoding |

## Verification
The properties assume only that `i_instr` is a known value at each rising edge once reset has been released. They assume nothing about which encodings appear, because illegal words are a legal input. The field-tracking property also assumes the cycle before the checked edge was out of reset, so it guards on the delayed reset. The bench changes the word only on falling edges, holds reset for several edges from time zero, and feeds every supported opcode and function code as well as illegal primary and secondary codes. It also uses destination-zero cases and an all-fields pattern, so each property sees both its triggering and non-triggering conditions.

// File: rtl/tfd_pkg.sv
package tfd_pkg;

    localparam int INSTR_W  = 32;
    localparam int OP_W     = 6;
    localparam int REG_W    = 5;
    localparam int FN_W     = 6;
    localparam int IMM_W    = 16;
    localparam int TGT_W    = INSTR_W - OP_W;
    localparam logic [REG_W-1:0] LINK_REG = '1;

    localparam logic [OP_W-1:0] OP_RFORM = 6'b000000;
    localparam logic [OP_W-1:0] OP_J     = 6'b000010;
    localparam logic [OP_W-1:0] OP_JAL   = 6'b000011;
    localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OP_BNE   = 6'b000101;
    localparam logic [OP_W-1:0] OP_ADDI  = 6'b001000;
    localparam logic [OP_W-1:0] OP_ORI   = 6'b001101;
    localparam logic [OP_W-1:0] OP_LUI   = 6'b001111;
    localparam logic [OP_W-1:0] OP_LW    = 6'b100011;
    localparam logic [OP_W-1:0] OP_SW    = 6'b101011;

    localparam logic [FN_W-1:0] FN_JR    = 6'b001000;
    localparam logic [FN_W-1:0] FN_ADD   = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB   = 6'b100010;
    localparam logic [FN_W-1:0] FN_SLT   = 6'b101010;

    typedef enum logic [1:0] {
        DST_RD   = 2'd0,
        DST_RT   = 2'd1,
        DST_LINK = 2'd2
    } dst_sel_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_SLT = 3'd2,
        ALU_OR  = 3'd3,
        ALU_UPR = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        EXT_SIGN  = 2'd0,
        EXT_ZERO  = 2'd1,
        EXT_UPPER = 2'd2
    } ext_mode_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] shamt;
        logic [FN_W-1:0]  funct;
        logic [IMM_W-1:0] imm;
        logic [TGT_W-1:0] target;
    } fields_t;

    typedef struct packed {
        logic             reg_we;
        dst_sel_e         dst_sel;
        logic [REG_W-1:0] dst_idx;
        alu_op_e          alu_op;
        ext_mode_e        ext_mode;
        logic             mem_rd;
        logic             mem_wr;
        logic             br_eq;
        logic             br_ne;
        logic             jump;
        logic             link;
        logic             jreg;
        logic             illegal;
    } ctrl_t;

    function automatic logic [REG_W-1:0] pick_dst(input dst_sel_e sel, input fields_t f);
        case (sel)
            DST_RT:   return f.rt;
            DST_LINK: return LINK_REG;
            default:  return f.rd;
        endcase
    endfunction

endpackage

// File: rtl/tfd_fields.sv
module tfd_fields
    import tfd_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output fields_t            fields
);
    localparam int RS_LO = INSTR_W - OP_W - REG_W;
    localparam int RT_LO = RS_LO - REG_W;
    localparam int RD_LO = RT_LO - REG_W;
    localparam int SH_LO = RD_LO - REG_W;

    always_comb begin
        fields.op     = instr[INSTR_W-1 -: OP_W];
        fields.rs     = instr[RS_LO +: REG_W];
        fields.rt     = instr[RT_LO +: REG_W];
        fields.rd     = instr[RD_LO +: REG_W];
        fields.shamt  = instr[SH_LO +: REG_W];
        fields.funct  = instr[FN_W-1:0];
        fields.imm    = instr[IMM_W-1:0];
        fields.target = instr[TGT_W-1:0];
    end
endmodule

// File: rtl/tfd_opdecode.sv
module tfd_opdecode
    import tfd_pkg::*;
(
    input  fields_t fields,
    output ctrl_t   ctrl
);
    logic     wants_wr;
    logic     bad;
    dst_sel_e sel;
    ctrl_t    c;

    always_comb begin
        c        = '0;
        wants_wr = 1'b0;
        bad      = 1'b0;
        sel      = DST_RD;
        case (fields.op)
            OP_RFORM: begin
                case (fields.funct)
                    FN_ADD: begin wants_wr = 1'b1; c.alu_op = ALU_ADD; end
                    FN_SUB: begin wants_wr = 1'b1; c.alu_op = ALU_SUB; end
                    FN_SLT: begin wants_wr = 1'b1; c.alu_op = ALU_SLT; end
                    FN_JR:  c.jreg = 1'b1;
                    default: bad = 1'b1;
                endcase
            end
            OP_ADDI: begin
                wants_wr = 1'b1; sel = DST_RT;
                c.alu_op = ALU_ADD; c.ext_mode = EXT_SIGN;
            end
            OP_ORI: begin
                wants_wr = 1'b1; sel = DST_RT;
                c.alu_op = ALU_OR; c.ext_mode = EXT_ZERO;
            end
            OP_LUI: begin
                wants_wr = 1'b1; sel = DST_RT;
                c.alu_op = ALU_UPR; c.ext_mode = EXT_UPPER;
            end
            OP_LW: begin
                wants_wr = 1'b1; sel = DST_RT;
                c.alu_op = ALU_ADD; c.ext_mode = EXT_SIGN; c.mem_rd = 1'b1;
            end
            OP_SW: begin
                c.alu_op = ALU_ADD; c.ext_mode = EXT_SIGN; c.mem_wr = 1'b1;
            end
            OP_BEQ: begin c.alu_op = ALU_SUB; c.br_eq = 1'b1; end
            OP_BNE: begin c.alu_op = ALU_SUB; c.br_ne = 1'b1; end
            OP_J:   c.jump = 1'b1;
            OP_JAL: begin
                wants_wr = 1'b1; sel = DST_LINK;
                c.jump = 1'b1; c.link = 1'b1;
            end
            default: bad = 1'b1;
        endcase

        if (wants_wr) begin
            c.dst_sel = sel;
            c.dst_idx = pick_dst(sel, fields);
            c.reg_we  = (c.dst_idx != '0);
        end

        if (bad) begin
            c         = '0;
            c.illegal = 1'b1;
        end
        ctrl = c;
    end
endmodule

// File: rtl/tfd_stage.sv
module tfd_stage
    import tfd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  fields_t fields_d,
    input  ctrl_t   ctrl_d,
    output fields_t fields_q,
    output ctrl_t   ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fields_q <= '0;
            ctrl_q   <= '0;
        end else begin
            fields_q <= fields_d;
            ctrl_q   <= ctrl_d;
        end
    end
endmodule

// File: rtl/tfd_decoder.sv
module tfd_decoder
    import tfd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [INSTR_W-1:0]  i_instr,
    output logic [REG_W-1:0]    o_rs,
    output logic [REG_W-1:0]    o_rt,
    output logic [REG_W-1:0]    o_rd,
    output logic [REG_W-1:0]    o_shamt,
    output logic [IMM_W-1:0]    o_imm,
    output logic [TGT_W-1:0]    o_target,
    output logic                o_reg_we,
    output logic [1:0]          o_dst_sel,
    output logic [REG_W-1:0]    o_dst_idx,
    output logic [2:0]          o_alu_op,
    output logic [1:0]          o_ext_mode,
    output logic                o_mem_rd,
    output logic                o_mem_wr,
    output logic                o_br_eq,
    output logic                o_br_ne,
    output logic                o_jump,
    output logic                o_link,
    output logic                o_jreg,
    output logic                o_illegal
);
    fields_t f_d, f_q;
    ctrl_t   c_d, c_q;

    tfd_fields u_fields (
        .instr  (i_instr),
        .fields (f_d)
    );

    tfd_opdecode u_dec (
        .fields (f_d),
        .ctrl   (c_d)
    );

    tfd_stage u_stage (
        .clk      (clk),
        .rst      (rst),
        .fields_d (f_d),
        .ctrl_d   (c_d),
        .fields_q (f_q),
        .ctrl_q   (c_q)
    );

    logic unused_q;
    assign unused_q = ^{f_q.op, f_q.funct};

    assign o_rs       = f_q.rs;
    assign o_rt       = f_q.rt;
    assign o_rd       = f_q.rd;
    assign o_shamt    = f_q.shamt;
    assign o_imm      = f_q.imm;
    assign o_target   = f_q.target;
    assign o_reg_we   = c_q.reg_we;
    assign o_dst_sel  = c_q.dst_sel;
    assign o_dst_idx  = c_q.dst_idx;
    assign o_alu_op   = c_q.alu_op;
    assign o_ext_mode = c_q.ext_mode;
    assign o_mem_rd   = c_q.mem_rd;
    assign o_mem_wr   = c_q.mem_wr;
    assign o_br_eq    = c_q.br_eq;
    assign o_br_ne    = c_q.br_ne;
    assign o_jump     = c_q.jump;
    assign o_link     = c_q.link;
    assign o_jreg     = c_q.jreg;
    assign o_illegal  = c_q.illegal;
endmodule

// File: rtl/tfd_decoder_chk.sv
module tfd_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] i_instr,
    input logic [4:0]  o_rs,
    input logic [4:0]  o_dst_idx,
    input logic [1:0]  o_dst_sel,
    input logic        o_reg_we,
    input logic        o_mem_rd,
    input logic        o_mem_wr,
    input logic        o_br_eq,
    input logic        o_br_ne,
    input logic        o_jump,
    input logic        o_link,
    input logic        o_jreg,
    input logic        o_illegal
);
    // R2 and R1: source field follows the word one edge later
    p_rs_tracks_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (o_rs == $past(i_instr[25:21])));

    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        o_illegal |-> !(o_reg_we || o_mem_rd || o_mem_wr || o_br_eq ||
                        o_br_ne || o_jump || o_link || o_jreg));

    p_no_zero_write_r9: assert property (@(posedge clk) disable iff (rst)
        o_reg_we |-> (o_dst_idx != 5'd0));

    p_one_flow_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({o_br_eq, o_br_ne, o_jump, o_jreg}));

    p_mem_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(o_mem_rd && o_mem_wr));

    p_link_r8: assert property (@(posedge clk) disable iff (rst)
        o_link |-> (o_jump && o_reg_we && o_dst_idx == 5'd31 && o_dst_sel == 2'd2));

    p_jreg_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
        o_jreg |-> !(o_reg_we || o_mem_rd || o_mem_wr));
endmodule

bind tfd_decoder tfd_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .i_instr   (i_instr),
    .o_rs      (o_rs),
    .o_dst_idx (o_dst_idx),
    .o_dst_sel (o_dst_sel),
    .o_reg_we  (o_reg_we),
    .o_mem_rd  (o_mem_rd),
    .o_mem_wr  (o_mem_wr),
    .o_br_eq   (o_br_eq),
    .o_br_ne   (o_br_ne),
    .o_jump    (o_jump),
    .o_link    (o_link),
    .o_jreg    (o_jreg),
    .o_illegal (o_illegal)
);

// File: tb/tb_tfd_decoder.sv
module tb_tfd_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] i_instr = 32'd0;
    logic [4:0]  o_rs, o_rt, o_rd, o_shamt, o_dst_idx;
    logic [15:0] o_imm;
    logic [25:0] o_target;
    logic        o_reg_we, o_mem_rd, o_mem_wr, o_br_eq, o_br_ne;
    logic        o_jump, o_link, o_jreg, o_illegal;
    logic [1:0]  o_dst_sel, o_ext_mode;
    logic [2:0]  o_alu_op;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tfd_decoder dut (
        .clk(clk), .rst(rst), .i_instr(i_instr),
        .o_rs(o_rs), .o_rt(o_rt), .o_rd(o_rd), .o_shamt(o_shamt),
        .o_imm(o_imm), .o_target(o_target), .o_reg_we(o_reg_we),
        .o_dst_sel(o_dst_sel), .o_dst_idx(o_dst_idx), .o_alu_op(o_alu_op),
        .o_ext_mode(o_ext_mode), .o_mem_rd(o_mem_rd), .o_mem_wr(o_mem_wr),
        .o_br_eq(o_br_eq), .o_br_ne(o_br_ne), .o_jump(o_jump),
        .o_link(o_link), .o_jreg(o_jreg), .o_illegal(o_illegal)
    );

    function automatic logic [31:0] rf(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction
    function automatic logic [31:0] imf(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction
    function automatic logic [31:0] jf(input logic [5:0] op, input logic [25:0] t);
        return {op, t};
    endfunction
    // expected bundle: we, idx, sel, alu, ext, {mem_rd,mem_wr,br_eq,br_ne,jump,link,jreg,illegal}
    function automatic logic [20:0] ex(input logic we, input int idx, input int sel,
                                       input int alu, input int ext, input logic [7:0] fl);
        return {we, idx[4:0], sel[1:0], alu[2:0], ext[1:0], fl};
    endfunction

    localparam int NV = 18;
    localparam logic [31:0] VI [NV] = '{
        rf(1, 2, 3, 6'b100000),              // R3 add
        rf(4, 5, 8, 6'b100010),              // R3 sub
        rf(6, 7, 31, 6'b101010),             // R3 slt
        rf(1, 2, 0, 6'b100000),              // R9 add to r0
        rf(31, 0, 0, 6'b001000),             // R4 jr
        imf(6'b001000, 1, 5, 16'hFFFC),      // R5 addi
        imf(6'b001101, 2, 6, 16'h8001),      // R5 ori
        imf(6'b001111, 0, 7, 16'h003D),      // R5 lui
        imf(6'b100011, 3, 9, 16'h0020),      // R6 lw
        imf(6'b101011, 3, 10, 16'h0030),     // R6 sw
        imf(6'b000100, 17, 18, 16'h0019),    // R7 beq
        imf(6'b000101, 19, 20, 16'hFFF0),    // R7 bne
        jf(6'b000010, 26'd2500),             // R8 j
        jf(6'b000011, 26'd77),               // R8 jal
        jf(6'b111111, 26'h3FFFFFF),          // R10 bad opcode
        rf(1, 2, 3, 6'b000001),              // R10 bad funct
        imf(6'b100011, 4, 0, 16'h0004),      // R9 lw to r0
        imf(6'b001000, 4, 0, 16'h0001)       // R9 addi to r0
    };
    localparam logic [20:0] VE [NV] = '{
        ex(1, 3, 0, 0, 0, 8'b0000_0000),
        ex(1, 8, 0, 1, 0, 8'b0000_0000),
        ex(1, 31, 0, 2, 0, 8'b0000_0000),
        ex(0, 0, 0, 0, 0, 8'b0000_0000),
        ex(0, 0, 0, 0, 0, 8'b0000_0010),
        ex(1, 5, 1, 0, 0, 8'b0000_0000),
        ex(1, 6, 1, 3, 1, 8'b0000_0000),
        ex(1, 7, 1, 4, 2, 8'b0000_0000),
        ex(1, 9, 1, 0, 0, 8'b1000_0000),
        ex(0, 0, 0, 0, 0, 8'b0100_0000),
        ex(0, 0, 0, 1, 0, 8'b0010_0000),
        ex(0, 0, 0, 1, 0, 8'b0001_0000),
        ex(0, 0, 0, 0, 0, 8'b0000_1000),
        ex(1, 31, 2, 0, 0, 8'b0000_1100),
        ex(0, 0, 0, 0, 0, 8'b0000_0001),
        ex(0, 0, 0, 0, 0, 8'b0000_0001),
        ex(0, 0, 1, 0, 0, 8'b1000_0000),
        ex(0, 0, 1, 0, 0, 8'b0000_0000)
    };
    localparam int VR [NV] = '{3,3,3,9,4,5,5,5,6,6,7,7,8,8,10,10,9,9};

    function automatic logic [20:0] got();
        return {o_reg_we, o_dst_idx, o_dst_sel, o_alu_op, o_ext_mode,
                o_mem_rd, o_mem_wr, o_br_eq, o_br_ne, o_jump, o_link, o_jreg, o_illegal};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        i_instr = w;
        @(negedge clk);
    endtask

    logic [31:0] pat;

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                // R1 reset state
                check("R1", {got(), o_rs, o_rt, o_rd, o_shamt, o_imm, o_target}, '0);
                rst = 1'b0;

                for (int k = 0; k < NV; k++) begin
                    apply(VI[k]);
                    check($sformatf("R%0d vector %0d", VR[k], k), got(), VE[k]);
                end

                // R2: field positions on an illegal word
                pat = 32'hA5C396E7;
                apply(pat);
                check("R2 rs", o_rs, 14);
                check("R2 rt", o_rt, 3);
                check("R2 rd", o_rd, 18);
                check("R2 shamt", o_shamt, 27);
                check("R2 imm", o_imm, 16'h96E7);
                check("R2 target", o_target, 26'h1C396E7);
                check("R10 illegal word", got(), ex(0, 0, 0, 0, 0, 8'b0000_0001));

                // R1 latency: word changes, output keeps old value until edge
                @(negedge clk);
                i_instr = jf(6'b000010, 26'd5);
                #2;
                check("R1 hold before edge", o_illegal, 1);
                @(negedge clk);
                check("R1 after edge", o_jump, 1);

                // R1 reset mid-run clears outputs
                i_instr = jf(6'b000011, 26'd9);
                rst = 1'b1;
                @(negedge clk);
                check("R1 mid-run reset", {got(), o_target}, '0);
                rst = 1'b0;
                @(negedge clk);
                check("R8 jal after reset", got(), ex(1, 31, 2, 0, 0, 8'b0000_1100));
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule